// File: doc/BRIEF.md
# Line Activity and Status Monitor

This block sits behind the receiver of a 192 kbit/s four-wire subscriber bus. It watches the received serial bits, one per bit strobe, and keeps a bus-activity flag. The flag goes high when zeros show up densely enough: three zero bits inside any span of 48 received bit periods, which is about 250 µs at the line rate. Once high, the flag stays high until a run of 128 consecutive one bits has been received. Any zero restarts that run.

Once per frame the block also takes a snapshot of the line state into an eight-bit status byte for a host to read. The snapshot holds these fields:
- a combined sync/activity bit: framer lock while an activation request is pending and no deactivation request is present, bus activity otherwise;
- a received-INFO indication;
- flags for "sending INFO0" and "sending INFO1", where the INFO1 flag is only honoured in TE mode;
- the two-bit state code of the activation state machine.

The snapshot is taken only on the single-cycle frame tick. Every read inside one frame therefore returns the same value. The framer and the activation state machine are outside this block; only their outputs are sampled.

Top module: `line_status_monitor`

## Requirements
- R1: On a bit strobe, `bus_active_o` becomes 1 on the next cycle when the 48 most recent strobed bits, counting the current one, hold three or more zeros.
- R2: Once set, `bus_active_o` stays 1 through 127 consecutive strobed ones and drops to 0 in the cycle after the 128th consecutive one.
- R3: A strobed zero restarts the ones-run count, so a further 128 ones are needed before the flag clears.
- R4: After reset, `bus_active_o` is 0 and `status_o` is 8'h00.
- R5: Status bit 7 takes the value of `frame_locked_i` when `deact_req_i`=0 and `act_req_i`=1; otherwise it takes the value of `bus_active_o`, both sampled at the frame tick.
- R6: `status_o` changes only in the cycle after a `frame_tick_i` pulse and holds its value between ticks, whatever the inputs do.
- R7: Status bits 1:0 carry `link_state_i` as sampled at the tick: 00 deactivated, 01 synchronized, 10 activation request, 11 activated.
- R8: Status bit 6 holds `info_rx_i` and status bit 5 holds `tx_info0_i`, both sampled at the tick.
- R9: Status bit 4 holds `tx_info1_i` AND `te_mode_i` as sampled at the tick, so it is 0 whenever TE mode is off.
- R10: Status bits 3:2 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit_i | input | 1 | Received line bit |
| rx_strobe_i | input | 1 | One-cycle strobe qualifying `rx_bit_i` |
| frame_tick_i | input | 1 | One-cycle pulse, once per frame |
| frame_locked_i | input | 1 | Framer reports frame synchronization |
| act_req_i | input | 1 | Activation request |
| deact_req_i | input | 1 | Deactivation request |
| info_rx_i | input | 1 | INFO frames being received |
| tx_info0_i | input | 1 | INFO0 being transmitted |
| tx_info1_i | input | 1 | INFO1 being transmitted |
| te_mode_i | input | 1 | 1 = terminal-side (TE) mode |
| link_state_i | input | 2 | Activation state code |
| bus_active_o | output | 1 | Bus-activity flag |
| status_o | output | 8 | Per-frame status snapshot |

## Verification
Both results come out of a single register stage. `bus_active_o` reflects a strobed bit one clock after that strobe, and `status_o` reflects the sampled inputs one clock after the frame tick. The bench drives every strobe and every tick on a falling edge and samples on the next falling edge, which is exactly one rising edge later. It sweeps the spacing of three zeros across the 48-bit boundary, walks the ones run to 127 and then 128, and sweeps every request/lock/activity combination and all 64 field combinations. After each snapshot it changes the inputs without a tick and confirms that the byte is unchanged.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  typedef struct packed {
    logic       sync_act;
    logic       info_rx;
    logic       tx_info0;
    logic       tx_info1;
    logic [1:0] rsvd;
    logic [1:0] link_state;
  } status_t;
endpackage

// File: rtl/lsm_activity_detector.sv
module lsm_activity_detector #(
  parameter int WIN_BITS    = 48,
  parameter int ZERO_THRESH = 3,
  parameter int ONES_CLEAR  = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  input  logic bit_i,
  output logic active_o
);
  localparam int CW = $clog2(WIN_BITS + 1);
  localparam int RW = $clog2(ONES_CLEAR + 1);

  logic [WIN_BITS-1:0] win_q, win_d;
  logic [CW-1:0]       zcnt_q, zcnt_d;
  logic [RW-1:0]       run_q, run_d;
  logic                active_q, active_d;
  logic                is_zero;

  assign is_zero = ~bit_i;

  always_comb begin
    win_d    = win_q;
    zcnt_d   = zcnt_q;
    run_d    = run_q;
    active_d = active_q;
    if (strobe_i) begin
      win_d  = {win_q[WIN_BITS-2:0], is_zero};
      zcnt_d = zcnt_q + CW'(is_zero) - CW'(win_q[WIN_BITS-1]);
      if (is_zero)
        run_d = '0;
      else if (run_q != RW'(ONES_CLEAR))
        run_d = run_q + RW'(1);
      if (zcnt_d >= CW'(ZERO_THRESH))
        active_d = 1'b1;
      else if (run_d == RW'(ONES_CLEAR))
        active_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q    <= '0;
      zcnt_q   <= '0;
      run_q    <= '0;
      active_q <= 1'b0;
    end else if (strobe_i) begin
      win_q    <= win_d;
      zcnt_q   <= zcnt_d;
      run_q    <= run_d;
      active_q <= active_d;
    end
  end

  assign active_o = active_q;

  // R1: the flag only rises right after a strobed zero
  a_r1_rise_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> $past(strobe_i && !bit_i));
  // R1: the zero count never exceeds the window length
  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    zcnt_q <= CW'(WIN_BITS));
  // R2: the flag only falls after a strobed one that completes the run
  a_r2_fall_on_run: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_q) |-> ($past(strobe_i && bit_i) && $past(run_q) == RW'(ONES_CLEAR - 1)));
  // R3: a strobed zero restarts the run
  a_r3_zero_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && !bit_i) |=> run_q == '0);
endmodule

// File: rtl/lsm_status_snapshot.sv
module lsm_status_snapshot
  import lsm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       bus_active_i,
  input  logic       frame_locked_i,
  input  logic       act_req_i,
  input  logic       deact_req_i,
  input  logic       info_rx_i,
  input  logic       tx_info0_i,
  input  logic       tx_info1_i,
  input  logic       te_mode_i,
  input  logic [1:0] link_state_i,
  output status_t    status_o
);
  status_t snap_d, snap_q;
  logic    lock_view;

  assign lock_view = act_req_i & ~deact_req_i;

  always_comb begin
    snap_d            = snap_q;
    if (tick_i) begin
      snap_d.sync_act   = lock_view ? frame_locked_i : bus_active_i;
      snap_d.info_rx    = info_rx_i;
      snap_d.tx_info0   = tx_info0_i;
      snap_d.tx_info1   = tx_info1_i & te_mode_i;
      snap_d.rsvd       = 2'b00;
      snap_d.link_state = link_state_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      snap_q <= '0;
    else if (tick_i)
      snap_q <= snap_d;
  end

  assign status_o = snap_q;

  // R5: lock view reported while activation requested without deactivation
  a_r5_lock_view: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && act_req_i && !deact_req_i) |=> snap_q.sync_act == $past(frame_locked_i));
  // R6: snapshot holds between ticks
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(snap_q));
  // R9: INFO1 flag suppressed outside TE mode
  a_r9_info1_te_only: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !te_mode_i) |=> !snap_q.tx_info1);
  // R10: reserved bits stay clear
  a_r10_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    snap_q.rsvd == 2'b00);
endmodule

// File: rtl/line_status_monitor.sv
module line_status_monitor
  import lsm_pkg::*;
#(
  parameter int WIN_BITS    = 48,
  parameter int ZERO_THRESH = 3,
  parameter int ONES_CLEAR  = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_bit_i,
  input  logic       rx_strobe_i,
  input  logic       frame_tick_i,
  input  logic       frame_locked_i,
  input  logic       act_req_i,
  input  logic       deact_req_i,
  input  logic       info_rx_i,
  input  logic       tx_info0_i,
  input  logic       tx_info1_i,
  input  logic       te_mode_i,
  input  logic [1:0] link_state_i,
  output logic       bus_active_o,
  output logic [7:0] status_o
);
  logic    active;
  status_t snap;

  lsm_activity_detector #(
    .WIN_BITS   (WIN_BITS),
    .ZERO_THRESH(ZERO_THRESH),
    .ONES_CLEAR (ONES_CLEAR)
  ) u_act (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe_i(rx_strobe_i),
    .bit_i   (rx_bit_i),
    .active_o(active)
  );

  lsm_status_snapshot u_snap (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_i        (frame_tick_i),
    .bus_active_i  (active),
    .frame_locked_i(frame_locked_i),
    .act_req_i     (act_req_i),
    .deact_req_i   (deact_req_i),
    .info_rx_i     (info_rx_i),
    .tx_info0_i    (tx_info0_i),
    .tx_info1_i    (tx_info1_i),
    .te_mode_i     (te_mode_i),
    .link_state_i  (link_state_i),
    .status_o      (snap)
  );

  assign bus_active_o = active;
  assign status_o     = snap;
endmodule

// File: tb/line_status_monitor_test.sv
module line_status_monitor_test;
  logic clk, rst_n;
  logic rx_bit, rx_strobe, frame_tick, frame_locked, act_req, deact_req;
  logic info_rx, tx_info0, tx_info1, te_mode;
  logic [1:0] link_state;
  logic bus_active;
  logic [7:0] status;
  int checks, failures;
  bit done;

  line_status_monitor uut (
    .clk(clk), .rst_n(rst_n), .rx_bit_i(rx_bit), .rx_strobe_i(rx_strobe),
    .frame_tick_i(frame_tick), .frame_locked_i(frame_locked), .act_req_i(act_req),
    .deact_req_i(deact_req), .info_rx_i(info_rx), .tx_info0_i(tx_info0),
    .tx_info1_i(tx_info1), .te_mode_i(te_mode), .link_state_i(link_state),
    .bus_active_o(bus_active), .status_o(status)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    rx_bit = b; rx_strobe = 1'b1;
    @(negedge clk);
    rx_strobe = 1'b0;
  endtask

  task automatic send_ones(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
  endtask

  task automatic tick();
    @(negedge clk);
    frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
  endtask

  function automatic logic [7:0] exp_status(input logic ba);
    logic s;
    s = (act_req && !deact_req) ? frame_locked : ba;
    return {s, info_rx, tx_info0, tx_info1 & te_mode, 2'b00, link_state};
  endfunction

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    rst_n = 1'b0; rx_bit = 1'b1; rx_strobe = 1'b0; frame_tick = 1'b0;
    frame_locked = 1'b0; act_req = 1'b0; deact_req = 1'b0; info_rx = 1'b0;
    tx_info0 = 1'b0; tx_info1 = 1'b0; te_mode = 1'b0; link_state = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R4 reset flag", {7'b0, bus_active}, 8'h00);
    check("R4 reset status", status, 8'h00);

    // R1: three zeros spaced k ones apart; span 2k+3 bits must fit in 48
    for (int k = 18; k <= 26; k++) begin
      send_ones(128);
      check("R2 clear before sweep", {7'b0, bus_active}, 8'h00);
      send_bit(1'b0); send_ones(k); send_bit(1'b0); send_ones(k); send_bit(1'b0);
      check("R1 three zeros in window", {7'b0, bus_active}, {7'b0, (2*k + 3) <= 48});
    end

    // R2: 127 ones keep the flag, the 128th clears it
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
    check("R1 back-to-back zeros", {7'b0, bus_active}, 8'h01);
    send_ones(127);
    check("R2 held after 127 ones", {7'b0, bus_active}, 8'h01);
    send_ones(1);
    check("R2 cleared on 128th one", {7'b0, bus_active}, 8'h00);

    // R3: a zero in the run restarts it
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
    send_ones(100); send_bit(1'b0); send_ones(127);
    check("R3 run restarted by zero", {7'b0, bus_active}, 8'h01);
    send_ones(1);
    check("R3 cleared after full new run", {7'b0, bus_active}, 8'h00);

    // R5: sync/activity selection, all combinations
    for (int ba = 0; ba < 2; ba++) begin
      if (ba == 1) begin send_bit(1'b0); send_bit(1'b0); send_bit(1'b0); end
      else send_ones(128);
      for (int c = 0; c < 8; c++) begin
        act_req = c[0]; deact_req = c[1]; frame_locked = c[2];
        tick();
        check("R5 sync/activity bit", status, exp_status(ba[0]));
      end
    end
    send_ones(128);

    // R6..R10: field sweep, then hold check with inputs moved
    for (int v = 0; v < 64; v++) begin
      logic [7:0] snap;
      act_req = 1'b0; deact_req = 1'b0; frame_locked = 1'b0;
      link_state = v[1:0]; info_rx = v[2]; tx_info0 = v[3];
      tx_info1 = v[4]; te_mode = v[5];
      tick();
      snap = exp_status(1'b0);
      check("R7 R8 R9 R10 fields", status, snap);
      link_state = ~link_state; info_rx = ~info_rx; tx_info0 = ~tx_info0;
      tx_info1 = ~tx_info1; te_mode = ~te_mode; act_req = 1'b1; frame_locked = 1'b1;
      repeat (3) @(negedge clk);
      check("R6 hold between ticks", status, snap);
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule